// File: doc/BRIEF.md
# Per-CPU Inter-Processor Interrupt Unit

This block lets a small group of CPUs interrupt one another. Every CPU owns two doorbell channels. The "other" channel can be rung by any CPU, and a single write can ring it on any set of targets. The "self" channel is rung by the owning CPU on itself. All accesses arrive on one write port and one read port. Each access carries the index of the CPU that makes it, and the per-CPU registers act on that CPU's own state.

A CPU's request line is high while that CPU has a channel that is both pending and unmasked. The interrupted CPU reads its event register to find out which channel fired. That read also masks the reported channel. Software then acks the channel to drop its pending state, and clears the mask again so that the next doorbell gets through. Registers use word addresses: 0 identity, 1 event, 2 send, 3 ack, 4 mask-set, 5 mask-clear. In the ack, mask-set and mask-clear registers, and for the self doorbell in the send register, bit 0 selects "other" and bit 31 selects "self".

Top module: `ipi_unit`

## Requirements
- R1: After reset, every channel of every CPU is masked and not pending, all request lines are low, and an event read (address 1) returns 0.
- R2: A read of address 0 returns the index of the CPU that makes the read.
- R3: A write to address 2 with bit k set, for k below NUM_CPUS, makes the "other" channel of CPU k pending. Several CPUs can be targeted in one write, and unset bits leave their CPUs untouched.
- R4: A write to address 2 with bit 31 set makes the "self" channel of the writing CPU pending, and of no other CPU.
- R5: irq_out[i] is high exactly while CPU i has a channel that is pending and unmasked. An unmasked channel that is not pending does not raise the line.
- R6: Writing 1 to bit 0 or bit 31 at address 4 (mask-set) or address 5 (mask-clear) masks or unmasks that channel of the writing CPU. Zero bits and other CPUs are not affected.
- R7: Writing 1 to bit 0 or bit 31 at address 3 clears the pending state of that channel for the writing CPU only.
- R8: An event read returns {8'd0, 8'd4, 16'dN}, with N=1 for "other" and N=2 for "self". "Other" is reported first when both are live. The read returns 0 when no channel is live.
- R9: An event read that reports a channel masks that channel. The channel stays pending, so it is reported again once it is unmasked, unless it has been acked.
- R10: A send to a channel that is already pending merges into the existing pending state, and a single ack clears it.
- R11: Read data and rd_valid appear in the cycle after the one in which rd_en is high. rd_valid is low in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_cpu | input | CPU_W | Index of the CPU making the write |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_cpu | input | CPU_W | Index of the CPU making the read |
| rd_addr | input | ADDR_W | Word address of the read |
| rd_data | output | 32 | Read data, one cycle after rd_en |
| rd_valid | output | 1 | Read data valid |
| irq_out | output | NUM_CPUS | Per-CPU interrupt request lines |

## Verification
Sends go out with several target patterns: two non-adjacent CPUs plus bits beyond the CPU count, a repeat send to a CPU that is already pending, and a self doorbell. Checking the lines of every CPU shows whether the decoder confuses target bits, writer identity or channel positions. The event register is read with one channel live, with both live and with none live. These reads separate the priority order, the auto-mask and the empty word. The mask-set and mask-clear tests use zero data and writes from a different CPU, to show that masks stay per CPU and per bit.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  // word addresses of the register window
  localparam int OFS_WHO   = 0;
  localparam int OFS_EVENT = 1;
  localparam int OFS_SEND  = 2;
  localparam int OFS_ACK   = 3;
  localparam int OFS_MSET  = 4;
  localparam int OFS_MCLR  = 5;

  // channel index inside the 2-bit per-CPU vectors
  localparam int CH_OTHER = 0;
  localparam int CH_SELF  = 1;

  // bit positions in the ack / mask / send data words
  localparam int BIT_OTHER = 0;
  localparam int BIT_SELF  = 31;

  localparam logic [7:0]  EV_TYPE_IPI  = 8'd4;
  localparam logic [15:0] EV_NUM_OTHER = 16'd1;
  localparam logic [15:0] EV_NUM_SELF  = 16'd2;

  typedef struct packed {
    logic [1:0] raise;
    logic [1:0] ack;
    logic [1:0] mset;
    logic [1:0] mclr;
  } ch_cmd_t;

  function automatic logic [31:0] ev_word(input logic [1:0] pick);
    logic [31:0] w;
    w = '0;
    if (pick[CH_OTHER])     w = {8'd0, EV_TYPE_IPI, EV_NUM_OTHER};
    else if (pick[CH_SELF]) w = {8'd0, EV_TYPE_IPI, EV_NUM_SELF};
    return w;
  endfunction
endpackage

// File: rtl/ipi_rst_sync.sv
module ipi_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/ipi_wr_decode.sv
module ipi_wr_decode
  import ipi_pkg::*;
#(
  parameter int NUM_CPUS = 4,
  parameter int ADDR_W   = 4,
  parameter int CPU_W    = 2
) (
  input  logic                wr_en,
  input  logic [CPU_W-1:0]    wr_cpu,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [31:0]         wr_data,
  output ch_cmd_t             cmd [NUM_CPUS]
);
  logic [1:0] chan_bits;
  logic       hit_send, hit_ack, hit_mset, hit_mclr;

  always_comb begin
    chan_bits = '0;
    chan_bits[CH_OTHER] = wr_data[BIT_OTHER];
    chan_bits[CH_SELF]  = wr_data[BIT_SELF];
    hit_send = wr_en && (int'(wr_addr) == OFS_SEND);
    hit_ack  = wr_en && (int'(wr_addr) == OFS_ACK);
    hit_mset = wr_en && (int'(wr_addr) == OFS_MSET);
    hit_mclr = wr_en && (int'(wr_addr) == OFS_MCLR);
  end

  for (genvar i = 0; i < NUM_CPUS; i++) begin : g_cpu
    logic own;
    always_comb begin
      own = (wr_cpu == CPU_W'(i));
      cmd[i] = '0;
      cmd[i].raise[CH_OTHER] = hit_send && wr_data[i];
      cmd[i].raise[CH_SELF]  = hit_send && own && wr_data[BIT_SELF];
      cmd[i].ack  = (hit_ack  && own) ? chan_bits : 2'b00;
      cmd[i].mset = (hit_mset && own) ? chan_bits : 2'b00;
      cmd[i].mclr = (hit_mclr && own) ? chan_bits : 2'b00;
    end
  end
endmodule

// File: rtl/ipi_cpu_slice.sv
module ipi_cpu_slice
  import ipi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  ch_cmd_t    cmd,
  input  logic       ev_take,
  output logic [1:0] pick,
  output logic       irq
);
  logic [1:0] pend_q, pend_d;
  logic [1:0] mask_q, mask_d;
  logic [1:0] live;
  logic [1:0] auto_mask;
  logic       upd_en;

  always_comb begin
    live = pend_q & ~mask_q;
    pick = 2'b00;
    if (live[CH_OTHER])     pick[CH_OTHER] = 1'b1;
    else if (live[CH_SELF]) pick[CH_SELF]  = 1'b1;
    auto_mask = ev_take ? pick : 2'b00;
    // a new doorbell wins over an ack in the same cycle
    pend_d = (pend_q & ~cmd.ack) | cmd.raise;
    // an explicit unmask wins over the read's auto-mask
    mask_d = (mask_q | cmd.mset | auto_mask) & ~cmd.mclr;
    upd_en = ev_take || (|cmd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 2'b00;
      mask_q <= 2'b11;
    end else if (upd_en) begin
      pend_q <= pend_d;
      mask_q <= mask_d;
    end
  end

  assign irq = |live;

  for (genvar c = 0; c < 2; c++) begin : g_chk
    a_r3_raise_sets: assert property (@(posedge clk) disable iff (!rst_n)
      cmd.raise[c] |=> pend_q[c]);
    a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd.ack[c] && !cmd.raise[c]) |=> !pend_q[c]);
    a_r6_mclr_unmasks: assert property (@(posedge clk) disable iff (!rst_n)
      cmd.mclr[c] |=> !mask_q[c]);
    a_r6_mset_masks: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd.mset[c] && !cmd.mclr[c]) |=> mask_q[c]);
    a_r9_automask: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_take && pick[c] && !cmd.mclr[c]) |=> mask_q[c]);
    a_r9_keeps_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_take && pick[c] && !cmd.ack[c]) |=> pend_q[c]);
  end
  a_r8_one_pick: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick));
endmodule

// File: rtl/ipi_rd_port.sv
module ipi_rd_port
  import ipi_pkg::*;
#(
  parameter int NUM_CPUS = 4,
  parameter int ADDR_W   = 4,
  parameter int CPU_W    = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rd_en,
  input  logic [CPU_W-1:0]          rd_cpu,
  input  logic [ADDR_W-1:0]         rd_addr,
  input  logic [NUM_CPUS-1:0][1:0]  picks,
  output logic [NUM_CPUS-1:0]       ev_take,
  output logic [31:0]               rd_data,
  output logic                      rd_valid
);
  logic [1:0]  sel_pick;
  logic [31:0] word_d;
  logic [31:0] data_q;
  logic        valid_q;
  logic        hit_event;

  always_comb begin
    hit_event = rd_en && (int'(rd_addr) == OFS_EVENT);
    sel_pick  = 2'b00;
    ev_take   = '0;
    for (int i = 0; i < NUM_CPUS; i++) begin
      if (rd_cpu == CPU_W'(i)) begin
        sel_pick   = picks[i];
        ev_take[i] = hit_event;
      end
    end
    case (int'(rd_addr))
      OFS_WHO:   word_d = 32'(rd_cpu);
      OFS_EVENT: word_d = ev_word(sel_pick);
      default:   word_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= rd_en;
      if (rd_en) data_q <= word_d;
    end
  end

  assign rd_data  = data_q;
  assign rd_valid = valid_q;

  a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  a_r11_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
  a_r8_event_type: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_event && (|sel_pick)) |=> (rd_data[23:16] == EV_TYPE_IPI));
endmodule

// File: rtl/ipi_unit.sv
module ipi_unit
  import ipi_pkg::*;
#(
  parameter int NUM_CPUS = 4,   // at most 31: bit 31 of the send word is the self doorbell
  parameter int ADDR_W   = 4,
  localparam int CPU_W   = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [CPU_W-1:0]    wr_cpu,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [31:0]         wr_data,
  input  logic                rd_en,
  input  logic [CPU_W-1:0]    rd_cpu,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [31:0]         rd_data,
  output logic                rd_valid,
  output logic [NUM_CPUS-1:0] irq_out
);
  logic                     rst_n_s;
  ch_cmd_t                  cmd [NUM_CPUS];
  logic [NUM_CPUS-1:0][1:0] picks;
  logic [NUM_CPUS-1:0]      ev_take;

  ipi_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  ipi_wr_decode #(.NUM_CPUS(NUM_CPUS), .ADDR_W(ADDR_W), .CPU_W(CPU_W)) u_dec (
    .wr_en   (wr_en),
    .wr_cpu  (wr_cpu),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .cmd     (cmd)
  );

  for (genvar i = 0; i < NUM_CPUS; i++) begin : g_slice
    ipi_cpu_slice u_slice (
      .clk     (clk),
      .rst_n   (rst_n_s),
      .cmd     (cmd[i]),
      .ev_take (ev_take[i]),
      .pick    (picks[i]),
      .irq     (irq_out[i])
    );
  end

  ipi_rd_port #(.NUM_CPUS(NUM_CPUS), .ADDR_W(ADDR_W), .CPU_W(CPU_W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .rd_en    (rd_en),
    .rd_cpu   (rd_cpu),
    .rd_addr  (rd_addr),
    .picks    (picks),
    .ev_take  (ev_take),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    (!rst_n_s) |=> (irq_out == '0));
endmodule

// File: tb/sim_ipi_unit.sv
`timescale 1ns/1ps
module sim_ipi_unit;
  localparam int N  = 4;
  localparam int AW = 4;
  localparam int CW = 2;
  localparam int A_WHO = 0, A_EV = 1, A_SEND = 2, A_ACK = 3, A_MSET = 4, A_MCLR = 5;
  localparam logic [31:0] EV_OTHER = 32'h0004_0001;
  localparam logic [31:0] EV_SELF  = 32'h0004_0002;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en, rd_en;
  logic [CW-1:0] wr_cpu, rd_cpu;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [31:0]   wr_data, rd_data;
  logic          rd_valid;
  logic [N-1:0]  irq_out;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  ipi_unit #(.NUM_CPUS(N), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_cpu(wr_cpu), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_cpu(rd_cpu), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_valid(rd_valid), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int cpu, input int addr, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_cpu = CW'(cpu); wr_addr = AW'(addr); wr_data = data;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input int cpu, input int addr, output logic [31:0] data);
    @(negedge clk);
    check("R11 idle valid", 32'(rd_valid), 32'd0);
    rd_en = 1'b1; rd_cpu = CW'(cpu); rd_addr = AW'(addr);
    @(negedge clk);
    rd_en = 1'b0;
    check("R11 valid after read", 32'(rd_valid), 32'd1);
    data = rd_data;
  endtask

  task automatic irq_is(input string req, input logic [N-1:0] exp);
    @(negedge clk);
    check(req, 32'(irq_out), 32'(exp));
  endtask

  task automatic t_reset();
    logic [31:0] d;
    irq_is("R1 lines low", 4'b0000);
    for (int i = 0; i < N; i++) begin
      rd(i, A_EV, d);
      check("R1 empty event", d, 32'd0);
    end
  endtask

  task automatic t_who();
    logic [31:0] d;
    for (int i = 0; i < N; i++) begin
      rd(i, A_WHO, d);
      check("R2 identity", d, 32'(i));
    end
  endtask

  task automatic t_send();
    logic [31:0] d;
    for (int i = 1; i < N; i++) wr(i, A_MCLR, 32'h1);
    irq_is("R5 unmasked not pending", 4'b0000);
    wr(0, A_SEND, 32'h0000_00FA);
    irq_is("R3 multi target", 4'b1010);
    rd(1, A_EV, d);
    check("R8 other code", d, EV_OTHER);
    irq_is("R9 auto-mask", 4'b1000);
    rd(1, A_EV, d);
    check("R9 masked not reported", d, 32'd0);
    wr(1, A_MCLR, 32'h1);
    irq_is("R9 still pending", 4'b1010);
    wr(1, A_ACK, 32'h1);
    irq_is("R7 ack own cpu only", 4'b1000);
  endtask

  task automatic t_merge();
    logic [31:0] d;
    wr(2, A_SEND, 32'h8);
    irq_is("R10 merged send", 4'b1000);
    wr(3, A_ACK, 32'h1);
    irq_is("R10 one ack clears", 4'b0000);
    rd(3, A_EV, d);
    check("R10 nothing left", d, 32'd0);
  endtask

  task automatic t_self();
    logic [31:0] d;
    wr(2, A_MCLR, 32'h8000_0000);
    wr(2, A_SEND, 32'h8000_0000);
    irq_is("R4 self only on writer", 4'b0100);
    rd(2, A_EV, d);
    check("R8 self code", d, EV_SELF);
    irq_is("R9 self auto-mask", 4'b0000);
    wr(2, A_ACK, 32'h8000_0000);
    wr(2, A_MCLR, 32'h8000_0000);
    irq_is("R7 self acked", 4'b0000);
  endtask

  task automatic t_prio();
    logic [31:0] d;
    wr(0, A_MCLR, 32'h8000_0001);
    wr(0, A_SEND, 32'h8000_0001);
    irq_is("R3 R4 both on cpu0", 4'b0001);
    rd(0, A_EV, d);
    check("R8 other first", d, EV_OTHER);
    irq_is("R9 self still live", 4'b0001);
    rd(0, A_EV, d);
    check("R8 then self", d, EV_SELF);
    irq_is("R9 both masked", 4'b0000);
    rd(0, A_EV, d);
    check("R8 then empty", d, 32'd0);
    wr(0, A_ACK, 32'h8000_0001);
    wr(0, A_MCLR, 32'h8000_0001);
    irq_is("R7 both acked", 4'b0000);
  endtask

  task automatic t_mask();
    wr(1, A_MSET, 32'h0);
    wr(0, A_SEND, 32'h2);
    irq_is("R6 zero mask-set no effect", 4'b0010);
    wr(1, A_ACK, 32'h1);
    wr(1, A_MSET, 32'h1);
    wr(0, A_SEND, 32'h2);
    irq_is("R6 masked blocks line", 4'b0000);
    wr(3, A_MCLR, 32'h1);
    irq_is("R6 other cpu unmask no effect", 4'b0000);
    wr(1, A_MCLR, 32'h1);
    irq_is("R6 unmask raises line", 4'b0010);
    wr(1, A_ACK, 32'h1);
    irq_is("R7 final ack", 4'b0000);
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    wr_cpu = '0; rd_cpu = '0; wr_addr = '0; rd_addr = '0; wr_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_who();
    t_send();
    t_merge();
    t_self();
    t_prio();
    t_mask();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule